// File: doc/BRIEF.md
# Two-Bit Event State Source Controller

This block keeps a two-bit event state for each of a small set of interrupt sources. One bit is "presented" (P): a notification for the source has gone out and is not yet retired. The other is "queued" (Q): a further trigger arrived while P was set, or the source is masked. The block decides when a trigger becomes a notification toward the event queue. It folds repeated triggers into Q and replays a folded trigger when the source is retired.

Software reaches the state through a load/store port that carries a source index and an address offset. Each state-changing load swaps in a new value and returns the old one, so software can mask, unmask, retire and re-fire a source atomically. Each source is set to message style (pulse triggers, replay at end of interrupt) or level style (a held input line that fires again while it stays asserted). Two global flags enable end of interrupt by a single store and an address-fix mode for parts that decode the offset in the wrong nibble.

Top module: `pq_event_source`

## Requirements
- R1: After reset every source holds PQ = 01 (masked) and no notification is raised.
- R2: A load whose decoded command nibble (offset bits 11:8) is 0xC, 0xD, 0xE or 0xF forces PQ to the nibble's two low bits. Each load answers one cycle after the request with the old PQ in data bits 1:0 and zeros in bits 7:2. Other sources are not affected.
- R3: A load with command 0x8 returns PQ and leaves it unchanged.
- R4: A trigger on a message-style source with PQ = 00 moves it to 10 and raises that source's notify bit for exactly one cycle, one cycle after the trigger. With PQ = 10 a trigger moves it to 11 with no notification. With PQ = 01 or 11 a trigger changes nothing.
- R5: A load with command 0xA masks: PQ becomes 01 and the old P bit is saved. A load with command 0xB unmasks: PQ becomes 10 if the saved bit was set and 00 otherwise, with no notification, and the saved bit is cleared.
- R6: On a message-style source, a load with command 0x0 is an end of interrupt: PQ becomes 00. If the old Q was 1, the folded trigger is replayed: PQ becomes 10 and one notification is raised.
- R7: A load with command 0x9 on a message-style source sets PQ to 11 and then performs an end of interrupt, so it leaves PQ = 10 with one notification. On a level-style source it changes nothing.
- R8: On a level-style source the trigger input is a line. The line asserted while PQ = 00 moves PQ to 10 with one notification. A command 0x0 load sets PQ to 00 with no replay, so a line still asserted fires again in the same cycle.
- R9: A store with command 0x0 performs the source's end of interrupt only while the store-EOI enable is high, and is ignored otherwise. A store with command 0x4 acts as a trigger on a message-style source and is ignored on a level-style source. Stores to other commands are ignored.
- R10: With the address-fix flag high, the 12-bit offset is ORed with itself shifted left by four bits before the command nibble is taken. With the flag low the offset is used as given.
- R11: When a port operation and a trigger hit the same source in one cycle, the port operation applies first and the trigger then acts on its result. A source raises at most one notification per cycle.
- R12: A load with any other command nibble returns 0xFF and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | NSRC | Per-source trigger pulse (message style) or line level (level style) |
| level_mode_i | input | NSRC | Per-source style: 1 = level, 0 = message |
| store_eoi_en_i | input | 1 | Enables end of interrupt by store at command 0x0 |
| shift_fix_i | input | 1 | Address-fix mode for offset decoding |
| req_i | input | 1 | Port request valid |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_src_i | input | SRC_W | Source index of the request |
| req_off_i | input | 12 | Address offset of the request |
| rsp_valid_o | output | 1 | Load response valid, one cycle after a load |
| rsp_data_o | output | 8 | Load response data |
| notify_o | output | NSRC | Per-source notification pulse toward the queue |

## Verification
The case that needs care is a port operation and a trigger landing on the same source in the same cycle. The bench raises a trigger pulse in the same cycle as an end-of-interrupt load, once with Q set and once with Q clear, and in the same cycle as a mask load. It checks that the trigger acts on the result of the port operation: a replay followed by a trigger leaves 11 with a single notification, a plain retirement followed by a trigger leaves 10 with a notification, and a mask absorbs the trigger. On the level source the line is held high across the end of interrupt, and the bench checks that the source fires again in that same cycle.

// File: rtl/pq_event_source.sv
`timescale 1ns/1ps
module pq_event_source #(
  parameter int NSRC  = 4,
  parameter int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  trig_i,
  input  logic [NSRC-1:0]  level_mode_i,
  input  logic             store_eoi_en_i,
  input  logic             shift_fix_i,
  input  logic             req_i,
  input  logic             req_we_i,
  input  logic [SRC_W-1:0] req_src_i,
  input  logic [11:0]      req_off_i,
  output logic             rsp_valid_o,
  output logic [7:0]       rsp_data_o,
  output logic [NSRC-1:0]  notify_o
);

  localparam logic [3:0] C_EOI   = 4'h0;
  localparam logic [3:0] C_TRIG  = 4'h4;
  localparam logic [3:0] C_GET   = 4'h8;
  localparam logic [3:0] C_RETRG = 4'h9;
  localparam logic [3:0] C_MASK  = 4'hA;
  localparam logic [3:0] C_UNMSK = 4'hB;

  logic [1:0]      pq_q [NSRC];
  logic [1:0]      pq_n [NSRC];
  logic [NSRC-1:0] sp_q, sp_n, fire_n, hit;

  logic [11:0] eff_off;
  logic [3:0]  cmd;
  logic        ld, st, known_ld;

  assign eff_off  = shift_fix_i ? (req_off_i | {req_off_i[7:0], 4'b0000}) : req_off_i;
  assign cmd      = eff_off[11:8];
  assign ld       = req_i & ~req_we_i;
  assign st       = req_i &  req_we_i;
  assign known_ld = (cmd == C_EOI) || (cmd == C_GET) || (cmd == C_RETRG) ||
                    (cmd == C_MASK) || (cmd == C_UNMSK) || (cmd[3:2] == 2'b11);

  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      hit[s]    = req_i && (req_src_i == SRC_W'(s));
      pq_n[s]   = pq_q[s];
      sp_n[s]   = sp_q[s];
      fire_n[s] = 1'b0;
      if (hit[s] && ld) begin
        case (cmd)
          C_EOI: begin
            if (!level_mode_i[s] && pq_q[s][0]) begin
              pq_n[s]   = 2'b10;
              fire_n[s] = 1'b1;
            end else begin
              pq_n[s] = 2'b00;
            end
          end
          C_RETRG: begin
            if (!level_mode_i[s]) begin
              pq_n[s]   = 2'b10;
              fire_n[s] = 1'b1;
            end
          end
          C_MASK: begin
            pq_n[s] = 2'b01;
            sp_n[s] = pq_q[s][1];
          end
          C_UNMSK: begin
            pq_n[s] = sp_q[s] ? 2'b10 : 2'b00;
            sp_n[s] = 1'b0;
          end
          default: begin
            if (cmd[3:2] == 2'b11) pq_n[s] = cmd[1:0];
          end
        endcase
      end
      if (hit[s] && st && cmd == C_EOI && store_eoi_en_i) begin
        if (!level_mode_i[s] && pq_q[s][0]) begin
          pq_n[s]   = 2'b10;
          fire_n[s] = 1'b1;
        end else begin
          pq_n[s] = 2'b00;
        end
      end
      if (level_mode_i[s]) begin
        if (trig_i[s] && pq_n[s] == 2'b00) begin
          pq_n[s]   = 2'b10;
          fire_n[s] = 1'b1;
        end
      end else if (trig_i[s] || (hit[s] && st && cmd == C_TRIG)) begin
        if (pq_n[s] == 2'b00) begin
          pq_n[s]   = 2'b10;
          fire_n[s] = 1'b1;
        end else if (pq_n[s] == 2'b10) begin
          pq_n[s] = 2'b11;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSRC; s++) pq_q[s] <= 2'b01;
      sp_q        <= '0;
      notify_o    <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      for (int s = 0; s < NSRC; s++) pq_q[s] <= pq_n[s];
      sp_q        <= sp_n;
      notify_o    <= fire_n;
      rsp_valid_o <= ld;
      if (ld) rsp_data_o <= known_ld ? {6'b0, pq_q[req_src_i]} : 8'hFF;
    end
  end

  AST_RSP_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> rsp_valid_o); // R2

  for (genvar g = 0; g < NSRC; g++) begin : g_chk
    AST_NOTIFY_LEAVES_P: assert property (@(posedge clk) disable iff (!rst_n)
      notify_o[g] |-> pq_q[g][1]); // R4
    AST_NO_FIRE_WHILE_P: assert property (@(posedge clk) disable iff (!rst_n)
      (pq_q[g][1] && !hit[g]) |=> !notify_o[g]); // R11
    AST_MASK_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && hit[g] && cmd == C_MASK) |=> pq_q[g] == 2'b01); // R5
    AST_SET11_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && hit[g] && cmd == 4'hF) |=> pq_q[g] == 2'b11); // R2
    AST_GET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && hit[g] && cmd == C_GET && !trig_i[g]) |=> pq_q[g] == $past(pq_q[g])); // R3
  end

endmodule

// File: tb/test_pq_event_source.sv
`timescale 1ns/1ps
module test_pq_event_source;
  localparam int NSRC = 4;
  localparam int SRC_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:0] trig_i = '0, level_mode_i = 4'b0100, lines = '0;
  logic store_eoi_en_i = 1'b0, shift_fix_i = 1'b0;
  logic req_i = 1'b0, req_we_i = 1'b0;
  logic [SRC_W-1:0] req_src_i = '0;
  logic [11:0] req_off_i = '0;
  logic rsp_valid_o;
  logic [7:0] rsp_data_o;
  logic [NSRC-1:0] notify_o;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  pq_event_source #(.NSRC(NSRC)) i_pq_event_source (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .level_mode_i(level_mode_i),
    .store_eoi_en_i(store_eoi_en_i), .shift_fix_i(shift_fix_i),
    .req_i(req_i), .req_we_i(req_we_i), .req_src_i(req_src_i), .req_off_i(req_off_i),
    .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o), .notify_o(notify_o));

  always @(negedge clk) begin
    if (rst_n && rsp_valid_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2: unexpected response act=%h exp=none", rsp_data_o);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rsp_data_o !== e) begin
          errors++;
          $display("FAIL %s: load data act=%h exp=%h", t, rsp_data_o, e);
        end
      end
    end
  end

  task automatic ldt(input int src, input logic [11:0] off, input logic [7:0] e,
                     input logic [NSRC-1:0] pls, input string t);
    @(negedge clk);
    req_i = 1'b1; req_we_i = 1'b0; req_src_i = SRC_W'(src); req_off_i = off;
    trig_i = lines | pls;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    req_i = 1'b0; trig_i = lines;
  endtask

  task automatic ld(input int src, input logic [11:0] off, input logic [7:0] e, input string t);
    ldt(src, off, e, '0, t);
  endtask

  task automatic st(input int src, input logic [11:0] off);
    @(negedge clk);
    req_i = 1'b1; req_we_i = 1'b1; req_src_i = SRC_W'(src); req_off_i = off;
    @(negedge clk);
    req_i = 1'b0; req_we_i = 1'b0;
  endtask

  task automatic pulse(input logic [NSRC-1:0] v);
    @(negedge clk); trig_i = lines | v;
    @(negedge clk); trig_i = lines;
  endtask

  task automatic chk_ntf(input logic [NSRC-1:0] e, input string t);
    checks++;
    if (notify_o !== e) begin
      errors++;
      $display("FAIL %s: notify act=%b exp=%b", t, notify_o, e);
    end
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_ntf(4'b0000, "R1");
    ld(0, 12'h800, 8'h01, "R1");
    ld(3, 12'h800, 8'h01, "R1");
    ld(2, 12'h800, 8'h01, "R1");
    // R4: trigger while masked does nothing
    pulse(4'b0001); chk_ntf(4'b0000, "R4");
    ld(0, 12'h800, 8'h01, "R4");
    ld(0, 12'hC00, 8'h01, "R2"); chk_ntf(4'b0000, "R2");
    pulse(4'b0001); chk_ntf(4'b0001, "R4");
    ld(0, 12'h800, 8'h10 >> 3, "R4");
    pulse(4'b0001); chk_ntf(4'b0000, "R4");
    ld(0, 12'h800, 8'h03, "R4");
    // R6: end of interrupt with replay, then without
    ld(0, 12'h000, 8'h03, "R6"); chk_ntf(4'b0001, "R6");
    ld(0, 12'h800, 8'h02, "R6");
    ld(0, 12'h000, 8'h02, "R6"); chk_ntf(4'b0000, "R6");
    ld(0, 12'h800, 8'h00, "R6");
    // R5: mask and unmask
    ld(0, 12'hE00, 8'h00, "R2");
    ld(0, 12'hA00, 8'h02, "R5");
    ld(0, 12'h800, 8'h01, "R5");
    pulse(4'b0001); chk_ntf(4'b0000, "R5");
    ld(0, 12'hB00, 8'h01, "R5"); chk_ntf(4'b0000, "R5");
    ld(0, 12'h800, 8'h02, "R5");
    ld(0, 12'hC00, 8'h02, "R2");
    ld(0, 12'hA00, 8'h00, "R5");
    ld(0, 12'hB00, 8'h01, "R5");
    ld(0, 12'h800, 8'h00, "R5");
    // R7: retrigger on message source
    ld(0, 12'h900, 8'h00, "R7"); chk_ntf(4'b0001, "R7");
    ld(0, 12'h800, 8'h02, "R7");
    // R9: store end of interrupt gated, store trigger
    ld(0, 12'hF00, 8'h02, "R2");
    st(0, 12'h000); chk_ntf(4'b0000, "R9");
    ld(0, 12'h800, 8'h03, "R9");
    store_eoi_en_i = 1'b1;
    st(0, 12'h000); chk_ntf(4'b0001, "R9");
    ld(0, 12'h800, 8'h02, "R9");
    store_eoi_en_i = 1'b0;
    ld(0, 12'hC00, 8'h02, "R2");
    st(0, 12'h400); chk_ntf(4'b0001, "R9");
    ld(0, 12'h800, 8'h02, "R9");
    // R11: port operation and trigger in one cycle
    ld(0, 12'hF00, 8'h02, "R2");
    ldt(0, 12'h000, 8'h03, 4'b0001, "R11"); chk_ntf(4'b0001, "R11");
    ld(0, 12'h800, 8'h03, "R11");
    ld(0, 12'hE00, 8'h03, "R2");
    ldt(0, 12'h000, 8'h02, 4'b0001, "R11"); chk_ntf(4'b0001, "R11");
    ld(0, 12'h800, 8'h02, "R11");
    ldt(0, 12'hA00, 8'h02, 4'b0001, "R11"); chk_ntf(4'b0000, "R11");
    ld(0, 12'h800, 8'h01, "R11");
    // R10: address-fix decoding
    shift_fix_i = 1'b1;
    ld(0, 12'h0C0, 8'h01, "R10"); chk_ntf(4'b0000, "R10");
    shift_fix_i = 1'b0;
    ld(0, 12'h0F0, 8'h00, "R10");
    ld(0, 12'h800, 8'h00, "R10");
    // R12: unknown commands
    ld(0, 12'h500, 8'hFF, "R12");
    ld(0, 12'h700, 8'hFF, "R12");
    st(0, 12'h800); chk_ntf(4'b0000, "R12");
    ld(0, 12'h800, 8'h00, "R12");
    ld(1, 12'h800, 8'h01, "R2");
    // R8: level source on index 2
    lines = 4'b0100;
    pulse(4'b0000); chk_ntf(4'b0000, "R8");
    ld(2, 12'hC00, 8'h01, "R8"); chk_ntf(4'b0100, "R8");
    ld(2, 12'h800, 8'h02, "R8"); chk_ntf(4'b0000, "R8");
    ld(2, 12'h000, 8'h02, "R8"); chk_ntf(4'b0100, "R8");
    ld(2, 12'h800, 8'h02, "R8");
    ld(2, 12'h900, 8'h02, "R7"); chk_ntf(4'b0000, "R7");
    ld(2, 12'h800, 8'h02, "R7");
    lines = 4'b0000;
    ld(2, 12'h000, 8'h02, "R8"); chk_ntf(4'b0000, "R8");
    ld(2, 12'h800, 8'h00, "R8");
    st(2, 12'h400); chk_ntf(4'b0000, "R9");
    ld(2, 12'h800, 8'h00, "R9");
    repeat (2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: missing responses act=%0d exp=0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule